// File: doc/BRIEF.md
# Display RAM Write Address Sequencer

This block sits between a host command decoder and a banked display memory of 128 columns by 13 banks, where each bank is one byte tall. For every data byte the host writes, it produces the physical column and bank to store it at, the byte to store and a one-cycle write enable. After each write it moves the logical pointer on by itself. The host therefore positions the pointer once and then streams bytes.

The pointer can advance along a row of columns (horizontal mode) or down a column of banks (vertical mode). It wraps at programmable column and bank limits rather than at the edges of the memory. A mirror option stores logical column 0 in the rightmost physical column. A bit-order option reverses each byte before storage, which puts its most significant bit at the bottom of the bank instead of the top.

Top module: `dram_wr_addr_seq`

## Requirements
- R1: The bank address driven to the memory never exceeds 12, and the column address never exceeds 127.
- R2: In horizontal mode (`cfg_vert`=0), each write increments the column pointer. A write at a column at or above the column limit sets the column to 0 and increments the bank.
- R3: In vertical mode (`cfg_vert`=1), each write increments the bank pointer. A write at a bank at or above the bank limit sets the bank to 0 and increments the column.
- R4: A write at the pointer position (column limit, bank limit) returns the pointer to (0,0) in both modes.
- R5: With `cfg_mirror`=0 the physical column equals the logical column. With `cfg_mirror`=1 it is 127 minus the logical column. The advance direction of the logical pointer is the same in both cases.
- R6: With `cfg_flip`=0 the stored byte equals the written byte. With `cfg_flip`=1, bit i of the stored byte is bit 7-i of the written byte.
- R7: After reset, the pointer is at (0,0), horizontal mode, no mirror and no flip are selected, the column limit is 127 and the bank limit is 12. `mem_we`, `mem_col`, `mem_bank` and `mem_data` are all 0.
- R8: An address-set strobe alone loads the pointer. A column above the column limit is clamped to the limit, and so is a bank above the bank limit. No memory write is issued.
- R9: `mem_we` is high for exactly the one cycle after the clock edge that samples `wr_stb`, and the address and data are valid in that same cycle. Cycles without a strobe leave the pointer unchanged.
- R10: When the address-set strobe and the write strobe come in the same cycle, the byte is stored at the newly loaded (clamped) address, and the pointer then advances from that address.
- R11: A configuration strobe updates mode and limits on its clock edge. A write in the same cycle uses the previous configuration. A bank limit above 12 is stored as 12.
- R12: When the limits are lowered below the current pointer, the next write still goes to the current pointer. The advance then wraps as if the pointer stood at the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load mode bits and limits |
| cfg_vert | input | 1 | 1 = vertical auto-advance |
| cfg_mirror | input | 1 | 1 = mirror columns |
| cfg_flip | input | 1 | 1 = reverse bit order of each byte |
| cfg_xlim | input | 7 | Column carriage limit |
| cfg_ylim | input | 4 | Bank carriage limit |
| set_addr | input | 1 | Load pointer from set_x / set_y |
| set_x | input | 7 | Column to load |
| set_y | input | 4 | Bank to load |
| wr_stb | input | 1 | Host data-write strobe |
| wr_data | input | 8 | Host data byte |
| mem_we | output | 1 | Memory write enable |
| mem_col | output | 7 | Physical column |
| mem_bank | output | 4 | Bank |
| mem_data | output | 8 | Byte to store |

## Verification
Two pairs of functions can land in the same cycle. An address-set strobe can arrive together with a write strobe, and a configuration strobe can arrive together with a write strobe. The bench drives both pairs on one edge, once with a set column above the limit so that clamping is involved. It judges the outcome by the column, bank and data stored on that edge and by the address of the write that follows. In the set-and-write case the byte must land at the clamped address and the pointer must advance from it. In the configuration-and-write case the byte must use the old mode, and only the next write may show the new one.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef struct packed {
    logic vert;
    logic mirror;
    logic flip;
  } wmode_t;
endpackage

// File: rtl/seq_cfg.sv
module seq_cfg
  import dram_seq_pkg::*;
#(
  parameter int COLS  = 128,
  parameter int BANKS = 13,
  parameter int XW    = 7,
  parameter int YW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  wmode_t        cfg_mode,
  input  logic [XW-1:0] cfg_xlim,
  input  logic [YW-1:0] cfg_ylim,
  output wmode_t        mode,
  output logic [XW-1:0] xlim,
  output logic [YW-1:0] ylim
);
  localparam logic [XW-1:0] XMAX = XW'(COLS - 1);
  localparam logic [YW-1:0] YMAX = YW'(BANKS - 1);

  function automatic logic [YW-1:0] clamp_y(input logic [YW-1:0] v);
    return (v > YMAX) ? YMAX : v;
  endfunction

  function automatic logic [XW-1:0] clamp_x(input logic [XW-1:0] v);
    return (v > XMAX) ? XMAX : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
      xlim <= XMAX;
      ylim <= YMAX;
    end else if (cfg_we) begin
      mode <= cfg_mode;
      xlim <= clamp_x(cfg_xlim);
      ylim <= clamp_y(cfg_ylim);
    end
  end
endmodule

// File: rtl/seq_ptr.sv
module seq_ptr #(
  parameter int XW = 7,
  parameter int YW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_addr,
  input  logic [XW-1:0] set_x,
  input  logic [YW-1:0] set_y,
  input  logic          adv,
  input  logic          vert,
  input  logic [XW-1:0] xlim,
  input  logic [YW-1:0] ylim,
  output logic [XW-1:0] ptr_x,
  output logic [YW-1:0] ptr_y,
  output logic [XW-1:0] cur_x,
  output logic [YW-1:0] cur_y,
  output logic          x_at_lim,
  output logic          y_at_lim
);
  logic [XW-1:0] nxt_x;
  logic [YW-1:0] nxt_y;

  function automatic logic [XW-1:0] sat_x(input logic [XW-1:0] v, input logic [XW-1:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic logic [YW-1:0] sat_y(input logic [YW-1:0] v, input logic [YW-1:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  // Effective address of this cycle: a set strobe overrides the held pointer.
  always_comb begin
    cur_x = set_addr ? sat_x(set_x, xlim) : ptr_x;
    cur_y = set_addr ? sat_y(set_y, ylim) : ptr_y;
  end

  assign x_at_lim = (cur_x >= xlim);
  assign y_at_lim = (cur_y >= ylim);

  always_comb begin
    nxt_x = cur_x;
    nxt_y = cur_y;
    if (!vert) begin
      if (x_at_lim) begin
        nxt_x = '0;
        nxt_y = y_at_lim ? '0 : cur_y + YW'(1);
      end else begin
        nxt_x = cur_x + XW'(1);
      end
    end else begin
      if (y_at_lim) begin
        nxt_y = '0;
        nxt_x = x_at_lim ? '0 : cur_x + XW'(1);
      end else begin
        nxt_y = cur_y + YW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_x <= '0;
      ptr_y <= '0;
    end else if (adv) begin
      ptr_x <= nxt_x;
      ptr_y <= nxt_y;
    end else if (set_addr) begin
      ptr_x <= cur_x;
      ptr_y <= cur_y;
    end
  end
endmodule

// File: rtl/seq_out.sv
module seq_out #(
  parameter int COLS = 128,
  parameter int XW   = 7,
  parameter int YW   = 4,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic [XW-1:0] cur_x,
  input  logic [YW-1:0] cur_y,
  input  logic          mirror,
  input  logic          flip,
  output logic          mem_we,
  output logic [XW-1:0] mem_col,
  output logic [YW-1:0] mem_bank,
  output logic [DW-1:0] mem_data
);
  logic [DW-1:0] rev_data;
  logic [XW-1:0] phys_col;

  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign rev_data[i] = wr_data[DW-1-i];
  end

  function automatic logic [XW-1:0] map_col(input logic [XW-1:0] x, input logic mir);
    return mir ? (XW'(COLS - 1) - x) : x;
  endfunction

  assign phys_col = map_col(cur_x, mirror);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we   <= 1'b0;
      mem_col  <= '0;
      mem_bank <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= wr_stb;
      if (wr_stb) begin
        mem_col  <= phys_col;
        mem_bank <= cur_y;
        mem_data <= flip ? rev_data : wr_data;
      end
    end
  end
endmodule

// File: rtl/dram_wr_addr_seq.sv
module dram_wr_addr_seq
  import dram_seq_pkg::*;
#(
  parameter int COLS  = 128,
  parameter int BANKS = 13,
  parameter int DW    = 8,
  localparam int XW   = $clog2(COLS),
  localparam int YW   = $clog2(BANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_vert,
  input  logic          cfg_mirror,
  input  logic          cfg_flip,
  input  logic [XW-1:0] cfg_xlim,
  input  logic [YW-1:0] cfg_ylim,
  input  logic          set_addr,
  input  logic [XW-1:0] set_x,
  input  logic [YW-1:0] set_y,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  output logic          mem_we,
  output logic [XW-1:0] mem_col,
  output logic [YW-1:0] mem_bank,
  output logic [DW-1:0] mem_data
);
  wmode_t        cfg_mode;
  wmode_t        mode;
  logic [XW-1:0] xlim;
  logic [YW-1:0] ylim;
  logic [XW-1:0] ptr_x;
  logic [YW-1:0] ptr_y;
  logic [XW-1:0] cur_x;
  logic [YW-1:0] cur_y;
  logic          x_at_lim;
  logic          y_at_lim;

  assign cfg_mode = '{vert: cfg_vert, mirror: cfg_mirror, flip: cfg_flip};

  seq_cfg #(.COLS(COLS), .BANKS(BANKS), .XW(XW), .YW(YW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_xlim(cfg_xlim), .cfg_ylim(cfg_ylim),
    .mode(mode), .xlim(xlim), .ylim(ylim)
  );

  seq_ptr #(.XW(XW), .YW(YW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .set_addr(set_addr), .set_x(set_x), .set_y(set_y),
    .adv(wr_stb), .vert(mode.vert), .xlim(xlim), .ylim(ylim),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .cur_x(cur_x), .cur_y(cur_y),
    .x_at_lim(x_at_lim), .y_at_lim(y_at_lim)
  );

  seq_out #(.COLS(COLS), .XW(XW), .YW(YW), .DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .cur_x(cur_x), .cur_y(cur_y), .mirror(mode.mirror), .flip(mode.flip),
    .mem_we(mem_we), .mem_col(mem_col), .mem_bank(mem_bank), .mem_data(mem_data)
  );
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int COLS  = 128,
  parameter int BANKS = 13,
  parameter int XW    = 7,
  parameter int YW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          set_addr,
  input logic          wr_stb,
  input logic          vert,
  input logic          mirror,
  input logic [XW-1:0] xlim,
  input logic [YW-1:0] ylim,
  input logic [XW-1:0] ptr_x,
  input logic [YW-1:0] ptr_y,
  input logic          mem_we,
  input logic [XW-1:0] mem_col,
  input logic [YW-1:0] mem_bank
);
  p_bank_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_bank <= YW'(BANKS - 1));

  p_horiz_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !set_addr && !vert && ptr_x < xlim) |=>
      (ptr_x == XW'($past(ptr_x) + 1'b1)) && (ptr_y == $past(ptr_y)));

  p_vert_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !set_addr && vert && ptr_y < ylim) |=>
      (ptr_y == YW'($past(ptr_y) + 1'b1)) && (ptr_x == $past(ptr_x)));

  p_corner_home_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !set_addr && ptr_x >= xlim && ptr_y >= ylim) |=>
      (ptr_x == '0) && (ptr_y == '0));

  p_col_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !set_addr && !mirror) |=> mem_col == $past(ptr_x));

  p_col_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !set_addr && mirror) |=> mem_col == XW'(XW'(COLS - 1) - $past(ptr_x)));

  p_we_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> mem_we);

  p_we_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> !mem_we);

  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !set_addr) |=> ($stable(ptr_x) && $stable(ptr_y)));

  p_bank_from_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !set_addr) |=> mem_bank == $past(ptr_y));

  p_cfg_ylim_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ylim <= YW'(BANKS - 1));
endmodule

bind dram_wr_addr_seq seq_chk #(.COLS(COLS), .BANKS(BANKS), .XW(XW), .YW(YW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .set_addr(set_addr), .wr_stb(wr_stb),
  .vert(mode.vert), .mirror(mode.mirror), .xlim(xlim), .ylim(ylim),
  .ptr_x(ptr_x), .ptr_y(ptr_y), .mem_we(mem_we), .mem_col(mem_col), .mem_bank(mem_bank)
);

// File: tb/dram_wr_addr_seq_tb.sv
module dram_wr_addr_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_vert = 1'b0, cfg_mirror = 1'b0, cfg_flip = 1'b0;
  logic [6:0] cfg_xlim = '0;
  logic [3:0] cfg_ylim = '0;
  logic       set_addr = 1'b0;
  logic [6:0] set_x = '0;
  logic [3:0] set_y = '0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       mem_we;
  logic [6:0] mem_col;
  logic [3:0] mem_bank;
  logic [7:0] mem_data;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dram_wr_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_vert(cfg_vert),
    .cfg_mirror(cfg_mirror), .cfg_flip(cfg_flip), .cfg_xlim(cfg_xlim),
    .cfg_ylim(cfg_ylim), .set_addr(set_addr), .set_x(set_x), .set_y(set_y),
    .wr_stb(wr_stb), .wr_data(wr_data), .mem_we(mem_we), .mem_col(mem_col),
    .mem_bank(mem_bank), .mem_data(mem_data)
  );

  // op: 0 cfg (a = column limit, b = {0,flip,mirror,vert,bank limit}),
  //     1 set (a = x, b = y), 2 write (a = data), 3 set + write (a = x, b = y, data 8'h77)
  localparam int NV = 22;
  localparam logic [41:0] VEC [NV] = '{
    {2'd1, 8'd126, 8'd0,  8'd0,   8'd0, 8'h00},   // R8
    {2'd2, 8'hA5,  8'd0,  8'd126, 8'd0, 8'hA5},   // R2
    {2'd2, 8'h01,  8'd0,  8'd127, 8'd0, 8'h01},   // R2
    {2'd2, 8'h80,  8'd0,  8'd0,   8'd1, 8'h80},   // R2 wrap
    {2'd0, 8'h03,  8'h62, 8'd0,   8'd0, 8'h00},   // mirror+flip, lim 3/2
    {2'd2, 8'h01,  8'd0,  8'd126, 8'd1, 8'h80},   // R5 R6
    {2'd2, 8'h0F,  8'd0,  8'd125, 8'd1, 8'hF0},   // R5 R6
    {2'd2, 8'h12,  8'd0,  8'd124, 8'd1, 8'h48},   // R2 R6
    {2'd1, 8'd3,   8'd2,  8'd0,   8'd0, 8'h00},   // R8
    {2'd2, 8'hC0,  8'd0,  8'd124, 8'd2, 8'h03},   // R4
    {2'd2, 8'hFF,  8'd0,  8'd127, 8'd0, 8'hFF},   // R4
    {2'd0, 8'h03,  8'h12, 8'd0,   8'd0, 8'h00},   // vertical
    {2'd2, 8'h11,  8'd0,  8'd1,   8'd0, 8'h11},   // R3
    {2'd2, 8'h22,  8'd0,  8'd1,   8'd1, 8'h22},   // R3
    {2'd2, 8'h33,  8'd0,  8'd1,   8'd2, 8'h33},   // R3
    {2'd2, 8'h44,  8'd0,  8'd2,   8'd0, 8'h44},   // R3 wrap
    {2'd1, 8'd9,   8'd15, 8'd0,   8'd0, 8'h00},   // R8 clamp
    {2'd2, 8'h55,  8'd0,  8'd3,   8'd2, 8'h55},   // R8 R4
    {2'd2, 8'h66,  8'd0,  8'd0,   8'd0, 8'h66},   // R4
    {2'd3, 8'd5,   8'd1,  8'd3,   8'd1, 8'h77},   // R10
    {2'd2, 8'h88,  8'd0,  8'd3,   8'd2, 8'h88},   // R10
    {2'd2, 8'h99,  8'd0,  8'd0,   8'd0, 8'h99}    // R4
  };

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cfg_we = 1'b0; set_addr = 1'b0; wr_stb = 1'b0;
  endtask

  task automatic do_cfg(input logic [6:0] xl, input logic [7:0] b, input bit with_wr,
                        input logic [7:0] d);
    cfg_we = 1'b1; cfg_xlim = xl; cfg_ylim = b[3:0];
    cfg_vert = b[4]; cfg_mirror = b[5]; cfg_flip = b[6];
    wr_stb = with_wr; wr_data = d;
    tick();
  endtask

  task automatic do_set(input logic [6:0] x, input logic [3:0] y);
    set_addr = 1'b1; set_x = x; set_y = y;
    tick();
  endtask

  task automatic do_wr(input logic [7:0] d);
    wr_stb = 1'b1; wr_data = d;
    tick();
  endtask

  task automatic expect_wr(input string req, input int col, input int bank, input int data);
    check({req, " we"}, int'(mem_we), 1);
    check({req, " col"}, int'(mem_col), col);
    check({req, " bank"}, int'(mem_bank), bank);
    check({req, " data"}, int'(mem_data), data);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R7 reset state of outputs
    check("R7 we", int'(mem_we), 0);
    check("R7 col", int'(mem_col), 0);
    check("R7 bank", int'(mem_bank), 0);
    check("R7 data", int'(mem_data), 0);
    rst_n = 1'b1;
    tick();
    // R7 default mode: first write at (0,0), no mirror, no flip
    do_wr(8'h3C);
    expect_wr("R7", 0, 0, 8'h3C);
    tick();
    check("R9 we idle", int'(mem_we), 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] a, b, ec, eb, ed;
      {op, a, b, ec, eb, ed} = VEC[i];
      case (op)
        2'd0: begin do_cfg(a[6:0], b, 1'b0, 8'h00); check("R11 cfg no write", int'(mem_we), 0); end
        2'd1: begin do_set(a[6:0], b[3:0]); check("R8 set no write", int'(mem_we), 0); end
        2'd2: begin do_wr(a); expect_wr($sformatf("R2-table vec %0d", i), ec, eb, ed); end
        default: begin
          set_addr = 1'b1; set_x = a[6:0]; set_y = b[3:0];
          wr_stb = 1'b1; wr_data = 8'h77;
          tick();
          expect_wr("R10 set+write", ec, eb, ed);
        end
      endcase
    end

    // R11 / R1: bank limit 15 stored as 12, vertical, column limit 127
    do_cfg(7'd127, 8'h1F, 1'b0, 8'h00);
    do_set(7'd0, 4'd11);
    do_wr(8'h01);
    expect_wr("R11 bank11", 0, 11, 8'h01);
    do_wr(8'h02);
    expect_wr("R1 bank12", 0, 12, 8'h02);
    do_wr(8'h03);
    expect_wr("R1 bank wrap", 1, 0, 8'h03);

    // R11: config and write in one cycle; write uses old (vertical, plain) mode
    do_cfg(7'd127, 8'h2C, 1'b1, 8'h01);
    expect_wr("R11 old cfg", 1, 1, 8'h01);
    do_wr(8'h02);
    expect_wr("R11 new cfg", 126, 2, 8'h02);

    // R12: limit lowered below the pointer
    do_set(7'd100, 4'd3);
    do_cfg(7'd3, 8'h0C, 1'b0, 8'h00);
    do_wr(8'h5A);
    expect_wr("R12 stale ptr", 100, 3, 8'h5A);
    do_wr(8'hA5);
    expect_wr("R12 wrap", 0, 4, 8'hA5);

    // R4 at full-size limits, horizontal
    do_cfg(7'd127, 8'h0C, 1'b0, 8'h00);
    do_set(7'd127, 4'd12);
    do_wr(8'h10);
    expect_wr("R4 full corner", 127, 12, 8'h10);
    do_wr(8'h20);
    expect_wr("R4 full home", 0, 0, 8'h20);

    // R9: pointer holds across idle cycles
    repeat (3) tick();
    check("R9 we idle", int'(mem_we), 0);
    do_wr(8'h30);
    expect_wr("R9 hold", 1, 0, 8'h30);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule